// File: doc/BRIEF.md
# Command Queue Descriptor Chain Walker

This block is the descriptor front end of a command-queue storage host. Each queued task owns one slot in a descriptor list. A slot holds a task descriptor, followed at once by a link descriptor. The link descriptor points into a separate table of transfer descriptors for that task.

A start strobe carries the task tag, the list base address and three layout controls:
- 64-bit versus 32-bit addressing;
- a 12-byte short transfer descriptor option;
- 128-bit versus 64-bit task descriptors.

The walker works out where the slot lies and reads the low 64 bits of the task descriptor. It then decodes the link and follows it. For every transfer descriptor it presents one (address, length) data segment, until it reaches the descriptor flagged as the final one.

All memory traffic goes through a plain 32-bit word-read port. The port carries one request at a time, and each response arrives at least one cycle after acceptance. The walker flags bad links, bad transfer descriptors and lists that run past a segment cap as errors. The consumer of the segments moves the data; the walker does not.

Top module: `cq_desc_walker`

## Requirements
- R1: On an accepted start, the slot address is list_base + tag × (task bytes + link bytes). Task bytes are 8, or 16 with task128_i. Link bytes are 16 with addr64_i, else 8. The words at slot and slot+4 appear on task_desc_o as {word@+4, word@slot}.
- R2: The link word sits at slot + task bytes. In its attribute word, bit 0 is valid, bit 1 is end and bits 5:3 are the action code. With valid=1, end=0 and action 6, the transfer table pointer is read from link+4 (low word) and, in 64-bit mode only, from link+8 (high word). In 32-bit mode the upper half of the pointer is zero.
- R3: A link with valid=0 and end=1 finishes the walk with done_o=1 and err_o=0. No segment is emitted and no word beyond the link word is read.
- R4: Any other link encoding finishes the walk with done_o and err_o both high and no segment emitted.
- R5: Consecutive transfer descriptors are 16 bytes apart in 64-bit mode and 12 bytes apart in 64-bit mode with short_xd_i. They are 8 bytes apart in 32-bit mode, where short_xd_i has no effect.
- R6: A transfer attribute word uses valid in bit 0, end in bit 1, action bits 5:3 equal to 4 and length in bits 31:16. One segment is emitted per descriptor. Its address comes from the word at +4, plus the word at +8 as the upper half in 64-bit mode (zero otherwise).
- R7: A length field of 0 is emitted as 65536 bytes on the 17-bit seg_len_o.
- R8: The segment from a descriptor with end=1 carries seg_last_o=1. done_o rises in the same cycle with err_o=0, and no further word is read.
- R9: A transfer descriptor with valid=0 or an action code other than 4 ends the walk with err_o=1. No segment is emitted for that descriptor.
- R10: After MAX_SEGS segments without an end flag, the walk ends with err_o=1 in the cycle of the last segment, and no further descriptor is read.
- R11: A memory request stays asserted with a stable address until accepted. At most one read is outstanding, and no request is made while idle.
- R12: After reset, busy_o, done_o, seg_valid_o and mem_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted while idle |
| tag_i | input | TAG_W | Task tag selecting the slot |
| list_base_i | input | 64 | Byte address of the descriptor list (4-byte aligned) |
| addr64_i | input | 1 | 64-bit addressing layout |
| short_xd_i | input | 1 | 12-byte transfer descriptors (64-bit mode only) |
| task128_i | input | 1 | 16-byte task descriptors |
| busy_o | output | 1 | Walk in progress |
| task_desc_o | output | 64 | Low 64 bits of the task descriptor |
| seg_valid_o | output | 1 | One-cycle segment strobe |
| seg_addr_o | output | 64 | Segment buffer address |
| seg_len_o | output | 17 | Segment length in bytes |
| seg_last_o | output | 1 | Segment is the final one of the task |
| done_o | output | 1 | One-cycle walk completion pulse |
| err_o | output | 1 | Walk aborted; valid with done_o |
| mem_req_o | output | 1 | Word read request |
| mem_addr_o | output | 64 | Byte address of the word requested |
| mem_ready_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |

## Verification
The bench builds the walker with TAG_W=5 and MAX_SEGS=4. Tag 31 then reaches the last slot of a 32-entry list. A five-descriptor chain without an early end hits the segment cap after only four segments. With these values, every combination of the three layout controls is cheap to cover: the 12-byte stride, the 32-bit case with the short option ignored, and the no-data link. A stalling memory that refuses every other request exercises the request-hold rule.

// File: rtl/cqw_pkg.sv
package cqw_pkg;

  localparam int ADDR_W = 64;
  localparam int WORD_W = 32;

  localparam logic [2:0] ACT_LINK = 3'd6;
  localparam logic [2:0] ACT_XFER = 3'd4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TASK_LO,
    ST_TASK_HI,
    ST_LINK,
    ST_PTR_LO,
    ST_PTR_HI,
    ST_XATTR,
    ST_XLO,
    ST_XHI
  } walk_st_e;

  typedef struct packed {
    logic a64;
    logic shrt;
    logic wide_task;
  } walk_cfg_t;

  typedef struct packed {
    logic        valid;
    logic        last;
    logic [2:0]  act;
    logic [15:0] len;
  } attr_t;

  function automatic attr_t unpack_attr(input logic [WORD_W-1:0] w);
    attr_t a;
    a.valid = w[0];
    a.last  = w[1];
    a.act   = w[5:3];
    a.len   = w[31:16];
    return a;
  endfunction

  function automatic logic [5:0] task_bytes(input walk_cfg_t c);
    return c.wide_task ? 6'd16 : 6'd8;
  endfunction

  function automatic logic [5:0] link_bytes(input walk_cfg_t c);
    return c.a64 ? 6'd16 : 6'd8;
  endfunction

  function automatic logic [5:0] slot_bytes(input walk_cfg_t c);
    return task_bytes(c) + link_bytes(c);
  endfunction

  function automatic logic [5:0] xfer_stride(input walk_cfg_t c);
    if (!c.a64) return 6'd8;
    return c.shrt ? 6'd12 : 6'd16;
  endfunction

  function automatic logic [16:0] seg_bytes(input logic [15:0] f);
    return (f == 16'd0) ? 17'h10000 : {1'b0, f};
  endfunction

endpackage

// File: rtl/cqw_addr.sv
module cqw_addr
  import cqw_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic [ADDR_W-1:0] list_base,
  input  logic [TAG_W-1:0]  tag,
  input  walk_cfg_t         cfg_now,
  input  walk_cfg_t         cfg_q,
  input  walk_st_e          state,
  input  logic [ADDR_W-1:0] slot_q,
  input  logic [ADDR_W-1:0] xd_q,
  output logic [ADDR_W-1:0] slot_addr,
  output logic [ADDR_W-1:0] fetch_addr
);

  localparam int OFF_W = TAG_W + 6;

  logic [OFF_W-1:0]  slot_off;
  logic [ADDR_W-1:0] link_addr;

  assign slot_off  = {6'b0, tag} * {{TAG_W{1'b0}}, slot_bytes(cfg_now)};
  assign slot_addr = list_base + ADDR_W'(slot_off);
  assign link_addr = slot_q + ADDR_W'(task_bytes(cfg_q));

  always_comb begin
    unique case (state)
      ST_TASK_LO: fetch_addr = slot_q;
      ST_TASK_HI: fetch_addr = slot_q + ADDR_W'(4);
      ST_LINK:    fetch_addr = link_addr;
      ST_PTR_LO:  fetch_addr = link_addr + ADDR_W'(4);
      ST_PTR_HI:  fetch_addr = link_addr + ADDR_W'(8);
      ST_XATTR:   fetch_addr = xd_q;
      ST_XLO:     fetch_addr = xd_q + ADDR_W'(4);
      ST_XHI:     fetch_addr = xd_q + ADDR_W'(8);
      default:    fetch_addr = slot_q;
    endcase
  end

endmodule

// File: rtl/cqw_rd_port.sv
module cqw_rd_port
  import cqw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              want,
  input  logic [ADDR_W-1:0] addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              got,
  output logic [WORD_W-1:0] data
);

  logic waiting_q;

  assign mem_req  = want && !waiting_q;
  assign mem_addr = addr;
  assign got      = waiting_q && mem_rvalid;
  assign data     = mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  waiting_q <= 1'b0;
    else if (mem_req && mem_ready) waiting_q <= 1'b1;
    else if (got)                waiting_q <= 1'b0;
  end

endmodule

// File: rtl/cqw_seq.sv
module cqw_seq
  import cqw_pkg::*;
#(
  parameter int MAX_SEGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  walk_cfg_t         cfg_in,
  input  logic [ADDR_W-1:0] slot_addr_in,
  input  logic              got,
  input  logic [WORD_W-1:0] rdata,
  output walk_st_e          state,
  output walk_cfg_t         cfg_q,
  output logic [ADDR_W-1:0] slot_q,
  output logic [ADDR_W-1:0] xd_q,
  output logic              want,
  output logic [63:0]       task_desc,
  output logic              seg_valid,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [16:0]       seg_len,
  output logic              seg_last,
  output logic              done,
  output logic              err,
  output logic              link_none,
  output logic              link_bad,
  output logic              xattr_bad,
  output logic              cap_hit
);

  localparam int CNT_W = $clog2(MAX_SEGS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_SEGS - 1);

  attr_t             a;
  logic              link_ok, seg_fire, finish, fail;
  logic [15:0]       len_q;
  logic              last_q;
  logic [WORD_W-1:0] alo_q;
  logic [CNT_W-1:0]  cnt_q;

  assign a         = unpack_attr(rdata);
  assign want      = (state != ST_IDLE);
  assign link_ok   = got && state == ST_LINK && a.valid && !a.last && a.act == ACT_LINK;
  assign link_none = got && state == ST_LINK && !a.valid && a.last;
  assign link_bad  = got && state == ST_LINK && !link_ok && !link_none;
  assign xattr_bad = got && state == ST_XATTR && (!a.valid || a.act != ACT_XFER);
  assign seg_fire  = got && ((state == ST_XLO && !cfg_q.a64) || state == ST_XHI);
  assign cap_hit   = seg_fire && !last_q && (cnt_q == CNT_LAST);
  assign fail      = link_bad || xattr_bad || cap_hit;
  assign finish    = link_none || fail || (seg_fire && last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cfg_q     <= '0;
      slot_q    <= '0;
      xd_q      <= '0;
      task_desc <= '0;
      len_q     <= '0;
      last_q    <= 1'b0;
      alo_q     <= '0;
      cnt_q     <= '0;
      seg_valid <= 1'b0;
      seg_addr  <= '0;
      seg_len   <= '0;
      seg_last  <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      seg_valid <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          cfg_q  <= cfg_in;
          slot_q <= slot_addr_in;
          cnt_q  <= '0;
          state  <= ST_TASK_LO;
        end
        ST_TASK_LO: if (got) begin
          task_desc[31:0] <= rdata;
          state <= ST_TASK_HI;
        end
        ST_TASK_HI: if (got) begin
          task_desc[63:32] <= rdata;
          state <= ST_LINK;
        end
        ST_LINK: if (link_ok) state <= ST_PTR_LO;
        ST_PTR_LO: if (got) begin
          xd_q  <= ADDR_W'(rdata);
          state <= cfg_q.a64 ? ST_PTR_HI : ST_XATTR;
        end
        ST_PTR_HI: if (got) begin
          xd_q[ADDR_W-1:WORD_W] <= rdata;
          state <= ST_XATTR;
        end
        ST_XATTR: if (got && !xattr_bad) begin
          len_q  <= a.len;
          last_q <= a.last;
          state  <= ST_XLO;
        end
        ST_XLO: if (got) begin
          alo_q <= rdata;
          if (cfg_q.a64) state <= ST_XHI;
        end
        default: ;
      endcase

      if (seg_fire) begin
        seg_valid <= 1'b1;
        seg_addr  <= (state == ST_XHI) ? {rdata, alo_q} : ADDR_W'(rdata);
        seg_len   <= seg_bytes(len_q);
        seg_last  <= last_q;
        cnt_q     <= cnt_q + 1'b1;
        xd_q      <= xd_q + ADDR_W'(xfer_stride(cfg_q));
        state     <= ST_XATTR;
      end

      if (finish) begin
        done  <= 1'b1;
        err   <= fail;
        state <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/cq_desc_walker.sv
module cq_desc_walker
  import cqw_pkg::*;
#(
  parameter int TAG_W    = 5,
  parameter int MAX_SEGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [63:0]       list_base_i,
  input  logic              addr64_i,
  input  logic              short_xd_i,
  input  logic              task128_i,
  output logic              busy_o,
  output logic [63:0]       task_desc_o,
  output logic              seg_valid_o,
  output logic [63:0]       seg_addr_o,
  output logic [16:0]       seg_len_o,
  output logic              seg_last_o,
  output logic              done_o,
  output logic              err_o,
  output logic              mem_req_o,
  output logic [63:0]       mem_addr_o,
  input  logic              mem_ready_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i
);

  walk_cfg_t         cfg_now, cfg_q;
  walk_st_e          state;
  logic [ADDR_W-1:0] slot_q, xd_q, slot_addr, fetch_addr;
  logic              want, got;
  logic [WORD_W-1:0] rd_data;
  logic              link_none, link_bad, xattr_bad, cap_hit;

  assign cfg_now.a64       = addr64_i;
  assign cfg_now.shrt      = short_xd_i;
  assign cfg_now.wide_task = task128_i;
  assign busy_o            = (state != ST_IDLE);

  cqw_addr #(.TAG_W(TAG_W)) u_addr (
    .list_base (list_base_i),
    .tag       (tag_i),
    .cfg_now   (cfg_now),
    .cfg_q     (cfg_q),
    .state     (state),
    .slot_q    (slot_q),
    .xd_q      (xd_q),
    .slot_addr (slot_addr),
    .fetch_addr(fetch_addr)
  );

  cqw_rd_port u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .want      (want),
    .addr      (fetch_addr),
    .mem_req   (mem_req_o),
    .mem_addr  (mem_addr_o),
    .mem_ready (mem_ready_i),
    .mem_rvalid(mem_rvalid_i),
    .mem_rdata (mem_rdata_i),
    .got       (got),
    .data      (rd_data)
  );

  cqw_seq #(.MAX_SEGS(MAX_SEGS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_i),
    .cfg_in      (cfg_now),
    .slot_addr_in(slot_addr),
    .got         (got),
    .rdata       (rd_data),
    .state       (state),
    .cfg_q       (cfg_q),
    .slot_q      (slot_q),
    .xd_q        (xd_q),
    .want        (want),
    .task_desc   (task_desc_o),
    .seg_valid   (seg_valid_o),
    .seg_addr    (seg_addr_o),
    .seg_len     (seg_len_o),
    .seg_last    (seg_last_o),
    .done        (done_o),
    .err         (err_o),
    .link_none   (link_none),
    .link_bad    (link_bad),
    .xattr_bad   (xattr_bad),
    .cap_hit     (cap_hit)
  );

endmodule

// File: rtl/cq_desc_walker_chk.sv
module cq_desc_walker_chk #(
  parameter int MAX_SEGS = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        busy_o,
  input logic        seg_valid_o,
  input logic        seg_last_o,
  input logic        done_o,
  input logic        err_o,
  input logic        mem_req_o,
  input logic [63:0] mem_addr_o,
  input logic        mem_ready_i,
  input logic        link_none,
  input logic        link_bad,
  input logic        xattr_bad,
  input logic        cap_hit
);

  logic [31:0] segs_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   segs_seen <= '0;
    else if (start_i && !busy_o)  segs_seen <= '0;
    else if (seg_valid_o)         segs_seen <= segs_seen + 1;
  end

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o);

  p_nodata_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    link_none |=> done_o && !err_o && !seg_valid_o);

  p_link_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    link_bad |=> done_o && err_o && !seg_valid_o);

  p_err_needs_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  p_xfer_bad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xattr_bad |=> done_o && err_o && !seg_valid_o);

  p_last_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid_o && seg_last_o |-> done_o && !err_o);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_cap_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> done_o && err_o && seg_valid_o && !seg_last_o);

  p_seg_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid_o |-> segs_seen < MAX_SEGS);

endmodule

bind cq_desc_walker cq_desc_walker_chk #(.MAX_SEGS(MAX_SEGS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .seg_valid_o(seg_valid_o),
  .seg_last_o (seg_last_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .mem_ready_i(mem_ready_i),
  .link_none  (link_none),
  .link_bad   (link_bad),
  .xattr_bad  (xattr_bad),
  .cap_hit    (cap_hit)
);

// File: tb/cq_desc_walker_test.sv
module cq_desc_walker_test;

  localparam int TAG_W    = 5;
  localparam int MAX_SEGS = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n, start_i, addr64_i, short_xd_i, task128_i;
  logic [TAG_W-1:0]  tag_i;
  logic [63:0]       list_base_i;
  logic              busy_o, seg_valid_o, seg_last_o, done_o, err_o, mem_req_o;
  logic [63:0]       task_desc_o, seg_addr_o, mem_addr_o;
  logic [16:0]       seg_len_o;
  logic              mem_ready_i, mem_rvalid_i;
  logic [31:0]       mem_rdata_i;

  cq_desc_walker #(.TAG_W(TAG_W), .MAX_SEGS(MAX_SEGS)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tag_i(tag_i),
    .list_base_i(list_base_i), .addr64_i(addr64_i), .short_xd_i(short_xd_i),
    .task128_i(task128_i), .busy_o(busy_o), .task_desc_o(task_desc_o),
    .seg_valid_o(seg_valid_o), .seg_addr_o(seg_addr_o), .seg_len_o(seg_len_o),
    .seg_last_o(seg_last_o), .done_o(done_o), .err_o(err_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ready_i(mem_ready_i),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
  );

  // memory model: one-cycle response, optional every-other-cycle stall
  logic [31:0] mem [0:1023];
  logic        stall_en = 1'b0;
  logic        stall_ph;
  int          reads = 0;

  assign mem_ready_i = !(stall_en && stall_ph);

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid_i <= 1'b0;
      stall_ph     <= 1'b0;
    end else begin
      stall_ph     <= ~stall_ph;
      mem_rvalid_i <= 1'b0;
      if (mem_req_o && mem_ready_i) begin
        mem_rvalid_i <= 1'b1;
        mem_rdata_i  <= mem[mem_addr_o[11:2]];
        reads        <= reads + 1;
      end
    end
  end

  // output monitor
  int          seg_n = 0, done_n = 0;
  logic        last_err = 1'b0;
  logic [63:0] sa  [64];
  logic [16:0] sl  [64];
  logic        slast [64];

  always @(negedge clk) begin
    if (seg_valid_o) begin
      sa[seg_n % 64]    = seg_addr_o;
      sl[seg_n % 64]    = seg_len_o;
      slast[seg_n % 64] = seg_last_o;
      seg_n++;
    end
    if (done_o) begin
      last_err = err_o;
      done_n++;
    end
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic int slot_sz(input bit a64, input bit t128);
    return (t128 ? 16 : 8) + (a64 ? 16 : 8);
  endfunction
  function automatic int xstride(input bit a64, input bit sh);
    return a64 ? (sh ? 12 : 16) : 8;
  endfunction
  function automatic int xbase(input int tag);
    return 'h800 + tag * 'h40;
  endfunction
  function automatic logic [31:0] seg_lo(input int tag, input int i);
    return 32'h1000_0000 | (tag << 12) | (i << 8);
  endfunction
  function automatic logic [31:0] seg_hi(input int i);
    return 32'h0000_00C0 + i;
  endfunction
  function automatic logic [15:0] seg_ln(input int tag, input int i);
    return 16'(16'h0200 + i * 16 + tag);
  endfunction
  function automatic int link_at(input int tag, input bit a64, input bit t128);
    return tag * slot_sz(a64, t128) + (t128 ? 16 : 8);
  endfunction

  task automatic build(input int tag, input bit a64, input bit sh, input bit t128, input int n);
    int s, l, d;
    for (int k = 0; k < 1024; k++) mem[k] = 32'h0;
    s = tag * slot_sz(a64, t128);
    mem[s / 4]     = 32'hA000_0000 | tag;
    mem[s / 4 + 1] = 32'h0B00_0000 | tag;
    l = link_at(tag, a64, t128);
    if (n == 0) mem[l / 4] = 32'h0000_0002;
    else begin
      mem[l / 4]     = 32'h0000_0031;
      mem[l / 4 + 1] = xbase(tag);
      if (a64) mem[l / 4 + 2] = 32'h0;
    end
    for (int i = 0; i < n; i++) begin
      d = xbase(tag) + i * xstride(a64, sh);
      mem[d / 4]     = {seg_ln(tag, i), 16'h0021} | ((i == n - 1) ? 32'h2 : 32'h0);
      mem[d / 4 + 1] = seg_lo(tag, i);
      if (a64) mem[d / 4 + 2] = seg_hi(i);
    end
  endtask

  task automatic run(input int tag, input bit a64, input bit sh, input bit t128,
                     output int sb, output int nseg, output int nrd);
    int d0, r0;
    sb = seg_n; d0 = done_n; r0 = reads;
    @(negedge clk);
    start_i = 1'b1; tag_i = tag[TAG_W-1:0];
    addr64_i = a64; short_xd_i = sh; task128_i = t128;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 400 && done_n == d0; k++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R8", "one done pulse", 64'(done_n - d0), 64'd1);
    nseg = seg_n - sb;
    nrd  = reads - r0;
  endtask

  // vector: {stall, nseg[2:0], task128, short, addr64, tag[4:0]}
  localparam logic [11:0] VEC [7] = '{
    {1'b0, 3'd3, 1'b0, 1'b0, 1'b1, 5'd0},
    {1'b0, 3'd4, 1'b1, 1'b1, 1'b1, 5'd31},
    {1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 5'd7},
    {1'b1, 3'd3, 1'b1, 1'b1, 1'b0, 5'd9},
    {1'b1, 3'd1, 1'b1, 1'b0, 1'b1, 5'd3},
    {1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 5'd12},
    {1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 5'd20}
  };

  initial begin
    int sb, ns, nr, tg, n, l;
    bit a64, sh, t128;
    rst_n = 1'b0; start_i = 1'b0; tag_i = '0; list_base_i = 64'h0;
    addr64_i = 1'b0; short_xd_i = 1'b0; task128_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12", "busy after reset", 64'(busy_o), 64'd0);
    chk("R12", "done after reset", 64'(done_o), 64'd0);
    chk("R12", "seg_valid after reset", 64'(seg_valid_o), 64'd0);
    chk("R12", "mem_req after reset", 64'(mem_req_o), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11", "no request while idle", 64'(mem_req_o), 64'd0);

    for (int v = 0; v < 7; v++) begin
      tg = int'(VEC[v][4:0]); a64 = VEC[v][5]; sh = VEC[v][6]; t128 = VEC[v][7];
      n = int'(VEC[v][10:8]); stall_en = VEC[v][11];
      build(tg, a64, sh, t128, n);
      run(tg, a64, sh, t128, sb, ns, nr);
      chk("R1", "task descriptor", task_desc_o,
          {32'h0B00_0000 | 32'(tg), 32'hA000_0000 | 32'(tg)});
      chk(n == 0 ? "R3" : "R6", "segment count", 64'(ns), 64'(n));
      chk(n == 0 ? "R3" : "R8", "error flag", 64'(last_err), 64'd0);
      chk("R5 R11", "read count", 64'(nr),
          64'(3 + ((n == 0) ? 0 : ((a64 ? 2 : 1) + n * (a64 ? 3 : 2)))));
      for (int i = 0; i < n && i < ns; i++) begin
        chk("R2 R5 R6", "segment address", sa[(sb + i) % 64],
            a64 ? {seg_hi(i), seg_lo(tg, i)} : {32'h0, seg_lo(tg, i)});
        chk("R6", "segment length", 64'(sl[(sb + i) % 64]), 64'(seg_ln(tg, i)));
        chk("R8", "last marker", 64'(slast[(sb + i) % 64]), 64'(i == n - 1));
      end
    end
    stall_en = 1'b0;

    // R4: link with valid but wrong action code
    build(5, 1, 0, 0, 2);
    l = link_at(5, 1, 0); mem[l / 4] = 32'h0000_0029;
    run(5, 1, 0, 0, sb, ns, nr);
    chk("R4", "bad link error", 64'(last_err), 64'd1);
    chk("R4", "bad link segments", 64'(ns), 64'd0);
    chk("R4", "bad link reads", 64'(nr), 64'd3);

    // R4: link with valid=0 and end=0
    build(6, 0, 0, 0, 2);
    l = link_at(6, 0, 0); mem[l / 4] = 32'h0;
    run(6, 0, 0, 0, sb, ns, nr);
    chk("R4", "empty link error", 64'(last_err), 64'd1);
    chk("R4", "empty link segments", 64'(ns), 64'd0);

    // R9: second transfer descriptor invalid
    build(8, 1, 0, 0, 3);
    mem[(xbase(8) + 16) / 4] = 32'h0;
    run(8, 1, 0, 0, sb, ns, nr);
    chk("R9", "invalid xfer error", 64'(last_err), 64'd1);
    chk("R9", "invalid xfer segments", 64'(ns), 64'd1);
    chk("R9", "invalid xfer reads", 64'(nr), 64'd9);

    // R9: first transfer descriptor with action code 5
    build(10, 0, 0, 1, 2);
    mem[xbase(10) / 4] = 32'h0200_0029;
    run(10, 0, 0, 1, sb, ns, nr);
    chk("R9", "bad act error", 64'(last_err), 64'd1);
    chk("R9", "bad act segments", 64'(ns), 64'd0);
    chk("R9", "bad act reads", 64'(nr), 64'd5);

    // R10: five-descriptor chain, cap of four
    build(2, 1, 0, 0, 5);
    run(2, 1, 0, 0, sb, ns, nr);
    chk("R10", "cap error", 64'(last_err), 64'd1);
    chk("R10", "cap segments", 64'(ns), 64'(MAX_SEGS));
    chk("R10", "cap reads", 64'(nr), 64'd17);
    chk("R10", "cap last marker", 64'(slast[(sb + 3) % 64]), 64'd0);

    // R7: zero length field
    build(4, 0, 0, 0, 1);
    mem[xbase(4) / 4] = 32'h0000_0023;
    run(4, 0, 0, 0, sb, ns, nr);
    chk("R7", "zero length segments", 64'(ns), 64'd1);
    chk("R7", "zero length value", 64'(sl[sb % 64]), 64'h10000);
    chk("R7", "zero length error", 64'(last_err), 64'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog: actual=hung expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule